// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Generator

This block produces four independent pulse-width-modulated outputs. Software programs each channel through a small synchronous register port that runs on a bus clock. The waveform counters run on a separate work clock. Every channel has its own mode word, a period and a duty value. The mode word holds an enable flag, a polarity flag and a 10-bit prescaler. The period and duty values are counted in prescaled ticks, and one tick lasts as many work-clock cycles as the prescaler says.

Each channel has a handshake synchronizer that moves its register values into the work domain as one coherent snapshot. The counters adopt a new snapshot only when a period ends or when the channel is freshly enabled. A change made while the output is running therefore never cuts a pulse short.

Top module: `quad_pwm`

## Requirements
- R1: After reset every register reads zero. Every output then sits at the inactive level of the inverted polarity, which is logic 1.
- R2: Channel c (0 to 3) owns the bytes from (c+1)*0x10 upward. In each bank the mode word is at +0x0, the period at +0x4 and the duty at +0x8. Writes to any other byte address are ignored, and reads from it return zero.
- R3: A read returns its data on `rsp_rdata` after the next bus clock edge. Mode bits 11:0 read back exactly as written, and so do the 16 bits of period and of duty. All higher bits read as zero, which lets software read, modify and write one mode field at a time.
- R4: Take mode bit 0 = 1 (enable), bit 1 = 1 (active-high) and bits 11:2 = prescaler D ≥ 1. With period P and duty K < P, the output is high for K*D work cycles and low for (P-K)*D work cycles, repeating.
- R5: Mode bit 1 = 0 selects inverted output. The active level is then 0 and the inactive level is 1, with the same timing as in R4.
- R6: A prescaler value of 0 behaves exactly like a value of 1.
- R7: On an enabled channel, a duty of 0 holds the output at the inactive level. Otherwise a duty ≥ period holds it at the active level.
- R8: A disabled channel drives the inactive level its polarity selects, and its counters stay at zero. Enabling it starts a period from its beginning with a full active pulse.
- R9: New prescaler, period or duty values reach a running channel only at a period boundary, so every pulse has either its old width or its new width.
- R10: The channels run independently. Reprogramming one channel leaves the waveforms of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| work_clk | input | 1 | Counter clock |
| work_rst_n | input | 1 | Active-low reset, work domain |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | One waveform output per channel |

## Verification
Register reads are due one bus edge after the request, so the bench samples `rsp_rdata` on the falling edge that follows the capturing edge. A waveform setting passes through a two-flop handshake in each direction and then waits out the rest of the running period. Its effect therefore has a bounded but clock-ratio-dependent delay. The bench waits a settle window longer than the worst such delay and then measures whole pulses, starting from a fresh inactive-to-active edge sampled on falling work-clock edges. The boundary-loading rule is checked by reprogramming duty in the middle of a pulse and requiring that every later pulse width is one of the two legal values.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int unsigned DIV_W     = 10;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned STRIDE_LG = 4;

  typedef enum logic [1:0] {
    SLOT_MODE   = 2'd0,
    SLOT_PERIOD = 2'd1,
    SLOT_DUTY   = 2'd2,
    SLOT_NONE   = 2'd3
  } slot_e;

  typedef struct packed {
    logic             en;
    logic             pol;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
  } chan_cfg_t;

  localparam int unsigned CFG_W = $bits(chan_cfg_t);

  // prescaler of zero counts as one
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction

  // period of zero counts as one tick
  function automatic logic [CNT_W-1:0] eff_period(input logic [CNT_W-1:0] p);
    return (p == '0) ? CNT_W'(1) : p;
  endfunction

  // active phase while the tick index is below duty
  function automatic logic in_active(input logic [CNT_W-1:0] tick,
                                     input logic [CNT_W-1:0] duty);
    return tick < duty;
  endfunction
endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
  import qpwm_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic [DATA_W-1:0]           rsp_rdata,
  output chan_cfg_t [N_CH-1:0]        cfg_o
);
  localparam int unsigned BANK_W = ADDR_W - STRIDE_LG;
  localparam int unsigned MODE_W = DIV_W + 2;

  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] ch_sel;
  slot_e             slot;
  logic              hit;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rsp_q;

  logic [N_CH-1:0][MODE_W-1:0] mode_rd;
  logic [N_CH-1:0][CNT_W-1:0]  per_rd;
  logic [N_CH-1:0][CNT_W-1:0]  duty_rd;

  always_comb begin
    bank   = req_addr[ADDR_W-1:STRIDE_LG];
    slot   = slot_e'(req_addr[STRIDE_LG-1:2]);
    hit    = (bank != '0) && (bank <= BANK_W'(N_CH)) && (slot != SLOT_NONE);
    ch_sel = bank - 1'b1;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_bank
    logic              wr_this;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  per_q;
    logic [CNT_W-1:0]  duty_q;

    assign wr_this = req_valid && req_write && hit && (ch_sel == BANK_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= '0;
        per_q  <= '0;
        duty_q <= '0;
      end else if (wr_this) begin
        case (slot)
          SLOT_MODE:   mode_q <= req_wdata[MODE_W-1:0];
          SLOT_PERIOD: per_q  <= req_wdata[CNT_W-1:0];
          SLOT_DUTY:   duty_q <= req_wdata[CNT_W-1:0];
          default:     ;
        endcase
      end
    end

    assign mode_rd[i] = mode_q;
    assign per_rd[i]  = per_q;
    assign duty_rd[i] = duty_q;
    assign cfg_o[i]   = '{en:     mode_q[0],
                          pol:    mode_q[1],
                          div:    mode_q[MODE_W-1:2],
                          period: per_q,
                          duty:   duty_q};
  end

  always_comb begin
    rd_next = '0;
    if (hit) begin
      for (int i = 0; i < N_CH; i++) begin
        if (ch_sel == BANK_W'(i)) begin
          case (slot)
            SLOT_MODE:   rd_next[MODE_W-1:0] = mode_rd[i];
            SLOT_PERIOD: rd_next[CNT_W-1:0]  = per_rd[i];
            SLOT_DUTY:   rd_next[CNT_W-1:0]  = duty_rd[i];
            default:     ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0;
    end else if (req_valid && !req_write) begin
      rsp_q <= rd_next;
    end
  end

  assign rsp_rdata = rsp_q;
endmodule

// File: rtl/qpwm_xfer.sv
module qpwm_xfer #(
  parameter int unsigned W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] src_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_data
);
  // source side: snapshot register and request toggle
  logic [W-1:0] hold_q;
  logic         req_q;
  logic         ack_s1, ack_s2;
  logic         busy;
  logic         launch;

  // destination side: request synchronizer and acknowledge toggle
  logic         req_d1, req_d2;
  logic         ack_q;
  logic [W-1:0] data_q;
  logic         take;

  assign busy   = req_q != ack_s2;
  assign launch = !busy && (src_data != hold_q);

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      hold_q <= '0;
      req_q  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= ack_q;
      ack_s2 <= ack_s1;
      if (launch) begin
        hold_q <= src_data;
        req_q  <= ~req_q;
      end
    end
  end

  assign take = req_d2 != ack_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_d1 <= 1'b0;
      req_d2 <= 1'b0;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      req_d1 <= req_q;
      req_d2 <= req_d1;
      if (take) begin
        data_q <= hold_q;
        ack_q  <= req_d2;
      end
    end
  end

  assign dst_data = data_q;
endmodule

// File: rtl/qpwm_chan.sv
module qpwm_chan
  import qpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg,
  output logic             pwm_o,
  output logic             run_o,
  output logic             load_o,
  output logic             act_pol_o,
  output logic [CNT_W-1:0] act_duty_o,
  output logic [CNT_W-1:0] act_per_o
);
  chan_cfg_t        act_q;
  logic             run_q;
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] tick_q;

  logic [DIV_W-1:0] div_lim;
  logic [CNT_W-1:0] per_lim;
  logic             tick_end;
  logic             per_end;
  logic             start;
  logic             load;

  always_comb begin
    div_lim  = eff_div(act_q.div) - 1'b1;
    per_lim  = eff_period(act_q.period) - 1'b1;
    tick_end = pre_q == div_lim;
    per_end  = tick_end && (tick_q == per_lim);
    start    = cfg.en && !run_q;
    load     = start || (run_q && cfg.en && per_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      run_q  <= 1'b0;
      pre_q  <= '0;
      tick_q <= '0;
    end else if (!cfg.en) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      tick_q <= '0;
    end else if (load) begin
      act_q  <= cfg;
      run_q  <= 1'b1;
      pre_q  <= '0;
      tick_q <= '0;
    end else if (tick_end) begin
      pre_q  <= '0;
      tick_q <= tick_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  always_comb begin
    if (run_q) begin
      pwm_o = in_active(tick_q, act_q.duty) ? act_q.pol : ~act_q.pol;
    end else begin
      pwm_o = ~cfg.pol;
    end
  end

  assign run_o      = run_q;
  assign load_o     = load;
  assign act_pol_o  = act_q.pol;
  assign act_duty_o = act_q.duty;
  assign act_per_o  = act_q.period;
endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import qpwm_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              work_clk,
  input  logic              work_rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [N_CH-1:0]   pwm_out
);
  chan_cfg_t [N_CH-1:0] cfg_bus;
  chan_cfg_t [N_CH-1:0] cfg_work;

  // named internal events for the bound checker
  logic [N_CH-1:0]            run_vec;
  logic [N_CH-1:0]            load_vec;
  logic [N_CH-1:0]            live_en_vec;
  logic [N_CH-1:0]            act_pol_vec;
  logic [N_CH-1:0][CNT_W-1:0] act_duty_vec;
  logic [N_CH-1:0][CNT_W-1:0] act_per_vec;

  qpwm_regs #(
    .N_CH  (N_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk      (bus_clk),
    .rst_n    (bus_rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata),
    .cfg_o    (cfg_bus)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [CFG_W-1:0] cfg_flat;

    qpwm_xfer #(.W(CFG_W)) u_xfer (
      .src_clk  (bus_clk),
      .src_rst_n(bus_rst_n),
      .src_data (cfg_bus[i]),
      .dst_clk  (work_clk),
      .dst_rst_n(work_rst_n),
      .dst_data (cfg_flat)
    );

    assign cfg_work[i]    = chan_cfg_t'(cfg_flat);
    assign live_en_vec[i] = cfg_work[i].en;

    qpwm_chan u_chan (
      .clk       (work_clk),
      .rst_n     (work_rst_n),
      .cfg       (cfg_work[i]),
      .pwm_o     (pwm_out[i]),
      .run_o     (run_vec[i]),
      .load_o    (load_vec[i]),
      .act_pol_o (act_pol_vec[i]),
      .act_duty_o(act_duty_vec[i]),
      .act_per_o (act_per_vec[i])
    );
  end
endmodule

// File: rtl/qpwm_chk.sv
module qpwm_chk
  import qpwm_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic                        bus_clk,
  input logic                        bus_rst_n,
  input logic                        work_clk,
  input logic                        work_rst_n,
  input logic                        req_valid,
  input logic                        req_write,
  input logic [ADDR_W-1:0]           req_addr,
  input logic [DATA_W-1:0]           rsp_rdata,
  input logic [N_CH-1:0]             pwm_out,
  input logic [N_CH-1:0]             run_vec,
  input logic [N_CH-1:0]             load_vec,
  input logic [N_CH-1:0]             live_en_vec,
  input logic [N_CH-1:0]             act_pol_vec,
  input logic [N_CH-1:0][CNT_W-1:0]  act_duty_vec,
  input logic [N_CH-1:0][CNT_W-1:0]  act_per_vec
);
  localparam int unsigned BANK_W = ADDR_W - STRIDE_LG;
  localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(N_CH);

  logic unmapped_rd;
  assign unmapped_rd = req_valid && !req_write &&
                       ((req_addr[ADDR_W-1:STRIDE_LG] == '0) ||
                        (req_addr[ADDR_W-1:STRIDE_LG] > TOP_BANK) ||
                        (req_addr[STRIDE_LG-1:2] == 2'd3));

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    unmapped_rd |=> (rsp_rdata == '0)) else $error("unmapped read returned data"); // R2

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    AST_LOAD_ONLY_AT_BOUNDARY: assert property (@(posedge work_clk) disable iff (!work_rst_n)
      (!$stable(act_per_vec[i]) || !$stable(act_duty_vec[i])) |-> $past(load_vec[i]))
      else $error("active config changed outside a load"); // R9

    AST_FULL_DUTY_ACTIVE: assert property (@(posedge work_clk) disable iff (!work_rst_n)
      (run_vec[i] && (act_per_vec[i] != '0) && (act_duty_vec[i] >= act_per_vec[i]))
      |-> (pwm_out[i] == act_pol_vec[i])) else $error("full duty left active level"); // R7

    AST_ZERO_DUTY_IDLE: assert property (@(posedge work_clk) disable iff (!work_rst_n)
      (run_vec[i] && (act_duty_vec[i] == '0)) |-> (pwm_out[i] != act_pol_vec[i]))
      else $error("zero duty showed active level"); // R7

    AST_DISABLE_STOPS: assert property (@(posedge work_clk) disable iff (!work_rst_n)
      !live_en_vec[i] |=> !run_vec[i]) else $error("channel kept running when disabled"); // R8
  end
endmodule

bind quad_pwm qpwm_chk #(
  .N_CH  (N_CH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .bus_clk     (bus_clk),
  .bus_rst_n   (bus_rst_n),
  .work_clk    (work_clk),
  .work_rst_n  (work_rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .rsp_rdata   (rsp_rdata),
  .pwm_out     (pwm_out),
  .run_vec     (run_vec),
  .load_vec    (load_vec),
  .live_en_vec (live_en_vec),
  .act_pol_vec (act_pol_vec),
  .act_duty_vec(act_duty_vec),
  .act_per_vec (act_per_vec)
);

// File: tb/quad_pwm_bench.sv
`timescale 1ns/1ps
module quad_pwm_bench;
  logic        bus_clk = 1'b0;
  logic        work_clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        work_rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 bus_clk = ~bus_clk;    // 125 MHz
  always #5 work_clk = ~work_clk;

  quad_pwm u_quad_pwm (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .work_clk  (work_clk),
    .work_rst_n(work_rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .pwm_out   (pwm_out)
  );

  // columns: channel, prescaler, period, duty, polarity
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{0, 1, 10, 3, 1},
    '{1, 3,  8, 2, 1},
    '{2, 2,  5, 4, 0},
    '{3, 0,  6, 1, 1},
    '{0, 4,  4, 2, 0},
    '{3, 10, 3, 1, 1}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int addr, input int data);
    @(negedge bus_clk);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 8'(addr);
    req_wdata = 32'(data);
    @(negedge bus_clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic bus_read(input int addr, output int data);
    @(negedge bus_clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 8'(addr);
    @(negedge bus_clk);
    req_valid = 1'b0;
    data = int'(rsp_rdata);
  endtask

  function automatic int base(input int ch);
    return (ch + 1) * 16;
  endfunction

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge work_clk);
  endtask

  // one full pulse from a fresh edge into the active level
  task automatic measure(input int ch, input logic lvl, output int hi, output int lo);
    int guard = 0;
    hi = 0;
    lo = 0;
    while (pwm_out[ch] == lvl && guard < 4000) begin @(negedge work_clk); guard++; end
    while (pwm_out[ch] != lvl && guard < 4000) begin @(negedge work_clk); guard++; end
    while (pwm_out[ch] == lvl && guard < 4000) begin hi++; @(negedge work_clk); guard++; end
    while (pwm_out[ch] != lvl && guard < 4000) begin lo++; @(negedge work_clk); guard++; end
  endtask

  task automatic count_off(input int ch, input logic lvl, input int n, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge work_clk);
      if (pwm_out[ch] != lvl) bad++;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rd, hi, lo, bad, eh, el, d;
    string tag;
    repeat (4) @(negedge bus_clk);
    bus_rst_n = 1'b1;
    work_rst_n = 1'b1;
    repeat (2) @(negedge bus_clk);

    // R1: reset contents and output levels
    chk("R1", "outputs after reset", pwm_out, 4'hF);
    bad = 0;
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 3; o++) begin
        bus_read(base(c) + 4 * o, rd);
        if (rd != 0) bad++;
      end
    end
    chk("R1", "nonzero registers after reset", bad, 0);

    // R2: unmapped addresses ignore writes and read zero
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_write(8'h1C, 32'hFFFF_FFFF);
    bus_read(8'h00, rd);  chk("R2", "read of bank below channels", rd, 0);
    bus_read(8'h50, rd);  chk("R2", "read of bank above channels", rd, 0);
    bus_read(8'h1C, rd);  chk("R2", "read of unused slot", rd, 0);
    bus_read(8'h10, rd);  chk("R2", "channel 0 mode untouched", rd, 0);
    bus_read(8'h20, rd);  chk("R2", "channel 1 mode untouched", rd, 0);

    // R3: field widths and read-modify-write
    bus_write(base(1) + 4, 32'hABCD_1234);
    bus_read(base(1) + 4, rd);  chk("R3", "period readback", rd, 32'h1234);
    bus_write(base(1) + 8, 32'hFFFF_FFFF);
    bus_read(base(1) + 8, rd);  chk("R3", "duty readback", rd, 32'hFFFF);
    bus_write(base(1), 32'h0000_0A5C);
    bus_read(base(1), rd);
    bus_write(base(1), rd | 2);
    bus_read(base(1), rd);      chk("R3", "mode read-modify-write", rd, 32'h0A5E);
    bus_write(base(1), 32'hFFFF_FFFF);
    bus_read(base(1), rd);      chk("R3", "mode upper bits", rd, 32'h0FFF);
    bus_write(base(1), 0);
    bus_write(base(1) + 4, 0);
    bus_write(base(1) + 8, 0);

    // table of waveform settings: R4 normal, R5 inverted, R6 zero prescaler
    for (int v = 0; v < NV; v++) begin
      bus_write(base(VEC[v][0]) + 4, VEC[v][2]);
      bus_write(base(VEC[v][0]) + 8, VEC[v][3]);
      bus_write(base(VEC[v][0]), (VEC[v][1] << 2) | (VEC[v][4] << 1) | 1);
      settle(120);
      d  = (VEC[v][1] == 0) ? 1 : VEC[v][1];
      eh = VEC[v][3] * d;
      el = (VEC[v][2] - VEC[v][3]) * d;
      tag = (VEC[v][1] == 0) ? "R6" : ((VEC[v][4] == 0) ? "R5" : "R4");
      measure(VEC[v][0], VEC[v][4] != 0, hi, lo);
      chk(tag, $sformatf("vector %0d active cycles", v), hi, eh);
      chk(tag, $sformatf("vector %0d inactive cycles", v), lo, el);
    end

    // R10: earlier channels kept their waveforms
    measure(0, 1'b0, hi, lo);
    chk("R10", "channel 0 active after others changed", hi, 8);
    chk("R10", "channel 0 inactive after others changed", lo, 8);
    measure(1, 1'b1, hi, lo);
    chk("R10", "channel 1 active after others changed", hi, 6);
    chk("R10", "channel 1 inactive after others changed", lo, 18);

    // R7: saturated and zero duty on channel 0
    bus_write(base(0), 0);
    bus_write(base(0) + 4, 5);
    bus_write(base(0) + 8, 5);
    bus_write(base(0), 7);
    settle(80);
    count_off(0, 1'b1, 100, bad);  chk("R7", "duty equal period not held high", bad, 0);
    bus_write(base(0) + 8, 9);
    settle(80);
    count_off(0, 1'b1, 100, bad);  chk("R7", "duty above period not held high", bad, 0);
    bus_write(base(0) + 8, 0);
    settle(80);
    count_off(0, 1'b0, 100, bad);  chk("R7", "zero duty not held low", bad, 0);
    bus_write(base(0) + 8, 5);
    bus_write(base(0), 5);
    settle(80);
    count_off(0, 1'b0, 100, bad);  chk("R7", "inverted full duty not held low", bad, 0);

    // R8: disabled levels and restart
    bus_write(base(0), 6);
    settle(60);
    count_off(0, 1'b0, 50, bad);   chk("R8", "disabled normal polarity level", bad, 0);
    bus_write(base(0), 4);
    settle(60);
    count_off(0, 1'b1, 50, bad);   chk("R8", "disabled inverted polarity level", bad, 0);
    bus_write(base(0) + 4, 10);
    bus_write(base(0) + 8, 4);
    bus_write(base(0), 6);
    settle(60);
    bus_write(base(0), 7);
    hi = 0;
    bad = 0;
    while (pwm_out[0] == 1'b0 && bad < 2000) begin @(negedge work_clk); bad++; end
    while (pwm_out[0] == 1'b1 && hi < 2000) begin hi++; @(negedge work_clk); end
    chk("R8", "first pulse after enable", hi, 4);

    // R9: duty changed in the middle of a pulse
    bus_write(base(2), 0);
    bus_write(base(2) + 4, 20);
    bus_write(base(2) + 8, 10);
    bus_write(base(2), 7);
    settle(100);
    while (pwm_out[2] == 1'b1) @(negedge work_clk);
    while (pwm_out[2] == 1'b0) @(negedge work_clk);
    settle(3);
    bus_write(base(2) + 8, 5);
    bad = 0;
    for (int p = 0; p < 4; p++) begin
      measure(2, 1'b1, hi, lo);
      if (!((hi == 10 && lo == 10) || (hi == 5 && lo == 15))) bad++;
    end
    chk("R9", "pulses with a width outside old or new", bad, 0);
    chk("R9", "active cycles after change", hi, 5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule